// File: doc/BRIEF.md
# Decrementer Timer with Status and Interrupt Logic

This block is a 32-bit down-counting timer with a control register, a status register, an auto-reload register and three interrupt lines. The counter steps down by one on every pulse of a time-base tick input. When it reaches zero it raises a decrementer flag in the status register. If auto-reload is enabled, it also copies the auto-reload register back into the counter. Two further flags, fixed-interval and watchdog, are set by external event inputs.

Software-side writes arrive on a single write port. A 2-bit selector picks the target: control, status, auto-reload or the counter itself. Status flags are write-one-to-clear. Each interrupt output is its status flag ANDed with an enable bit in the control register. The outputs are registered and follow the registers in the same cycle that the registers change, so an enable or clear takes effect on the cycle after the write.

The counter, the control register and the status register are brought out as outputs so that the surrounding logic can read them.

Top module: `dectimer_top`

## Requirements
- R1: A synchronous active-high reset clears the control register, status register, auto-reload register and counter, and drives all three interrupt outputs low.
- R2: A write with selector 0 loads all 32 bits of wr_data into the control register, visible on ctrl_q one cycle later. Control bit 26 enables the decrementer interrupt, bit 23 the fixed-interval interrupt, bit 27 the watchdog interrupt, and bit 22 auto-reload.
- R3: A write with selector 1 clears every status bit whose wr_data bit is 1 and leaves every other status bit unchanged.
- R4: fit_event sets status bit 26 and wdt_event sets status bit 30, one cycle later. A set arriving in the same cycle as a clear of that bit wins.
- R5: A tick with the counter above 1 and no counter write decrements the counter by exactly one.
- R6: A tick with the counter at 1 sets status bit 27 together with the counter reaching zero. With auto-reload off, the counter then holds at 0: further ticks change nothing and set no flag.
- R7: With control bit 22 set, a tick at counter value 1 loads the auto-reload register into the counter instead of 0, and still sets status bit 27.
- R8: A write with selector 3 loads wr_data into the counter and takes precedence over a tick in the same cycle. Writing 0 does not set status bit 27.
- R9: irq_dec equals status bit 27 AND control bit 26, irq_fit equals status bit 26 AND control bit 23, and irq_wdt equals status bit 30 AND control bit 27. Each output changes in the same cycle as the register that causes the change.
- R10: A write with selector 2 loads the auto-reload register without touching the counter. The value is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status, 2 auto-reload, 3 counter |
| wr_data | input | 32 | Write data |
| tick | input | 1 | Time-base tick, one cycle per count |
| fit_event | input | 1 | Sets the fixed-interval flag |
| wdt_event | input | 1 | Sets the watchdog flag |
| dec_value | output | 32 | Current counter value |
| ctrl_q | output | 32 | Control register |
| stat_q | output | 32 | Status register |
| irq_dec | output | 1 | Decrementer interrupt |
| irq_fit | output | 1 | Fixed-interval interrupt |
| irq_wdt | output | 1 | Watchdog interrupt |

## Verification
The hardest situations to reach are the collisions at the counter's 1-to-0 step. These include a tick together with a counter write, a status clear of bit 27 together with the zero crossing, and a reload while the auto-reload value is being rewritten. The stimulus loads small counter values directly so that each crossing is only a few ticks away, and then lines the colliding write up with the final tick. A behavioural reference model in the bench is compared against every output on every clock, which also catches a flag or interrupt that moves when it should hold still.

// File: rtl/dectimer_pkg.sv
package dectimer_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_STAT   = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_COUNT  = 2'd3
  } wr_sel_e;

  // status flag positions
  localparam int ST_WDT = 30;
  localparam int ST_DEC = 27;
  localparam int ST_FIT = 26;
  // control enable positions
  localparam int CT_WDT_EN = 27;
  localparam int CT_DEC_EN = 26;
  localparam int CT_FIT_EN = 23;
  localparam int CT_RELOAD = 22;

  localparam int N_IRQ = 3;
endpackage

// File: rtl/dectimer_cfg.sv
module dectimer_cfg
  import dectimer_pkg::*;
#(
  parameter int W = REG_W,
  parameter int CW = W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  ctrl_q,
  output logic [W-1:0]  ctrl_nxt,
  output logic [CW-1:0] reload_q
);
  logic [CW-1:0] reload_nxt;

  always_comb begin
    ctrl_nxt   = ctrl_q;
    reload_nxt = reload_q;
    if (wr_en && wr_sel == SEL_CTRL)   ctrl_nxt   = wr_data;
    if (wr_en && wr_sel == SEL_RELOAD) reload_nxt = wr_data[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_nxt;
      reload_q <= reload_nxt;
    end
  end
endmodule

// File: rtl/dectimer_count.sv
module dectimer_count
  import dectimer_pkg::*;
#(
  parameter int CW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  input  logic          reload_en,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt_q,
  output logic          zero_hit
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_nxt;

  always_comb begin
    zero_hit = 1'b0;
    cnt_nxt  = cnt_q;
    if (load) begin
      cnt_nxt = load_val;
    end else if (tick && cnt_q != '0) begin
      if (cnt_q == ONE) begin
        zero_hit = 1'b1;
        cnt_nxt  = reload_en ? reload_val : '0;
      end else begin
        cnt_nxt = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/dectimer_status.sv
module dectimer_status
  import dectimer_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic         set_dec,
  input  logic         set_fit,
  input  logic         set_wdt,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_nxt
);
  logic [W-1:0] set_mask;

  always_comb begin
    set_mask         = '0;
    set_mask[ST_DEC] = set_dec;
    set_mask[ST_FIT] = set_fit;
    set_mask[ST_WDT] = set_wdt;
    stat_nxt = (clr_en ? (stat_q & ~clr_mask) : stat_q) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_nxt;
  end
endmodule

// File: rtl/dectimer_irq.sv
module dectimer_irq
  import dectimer_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = N_IRQ
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_nxt,
  input  logic [W-1:0] ctrl_nxt,
  output logic [N-1:0] irq_q
);
  // channel 0: decrementer, 1: fixed-interval, 2: watchdog
  localparam int FLAG_POS [N_IRQ] = '{ST_DEC, ST_FIT, ST_WDT};
  localparam int EN_POS   [N_IRQ] = '{CT_DEC_EN, CT_FIT_EN, CT_WDT_EN};

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= stat_nxt[FLAG_POS[g]] & ctrl_nxt[EN_POS[g]];
    end
  end
endmodule

// File: rtl/dectimer_top.sv
module dectimer_top
  import dectimer_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             tick,
  input  logic             fit_event,
  input  logic             wdt_event,
  output logic [W-1:0]     dec_value,
  output logic [W-1:0]     ctrl_q,
  output logic [W-1:0]     stat_q,
  output logic             irq_dec,
  output logic             irq_fit,
  output logic             irq_wdt
);
  logic [W-1:0]     ctrl_nxt;
  logic [W-1:0]     stat_nxt;
  logic [W-1:0]     reload_q;
  logic             zero_hit;
  logic [N_IRQ-1:0] irq_q;

  dectimer_cfg #(.W(W), .CW(W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt), .reload_q(reload_q)
  );

  dectimer_count #(.CW(W)) u_count (
    .clk(clk), .rst(rst),
    .load(wr_en && wr_sel == SEL_COUNT), .load_val(wr_data),
    .tick(tick), .reload_en(ctrl_q[CT_RELOAD]), .reload_val(reload_q),
    .cnt_q(dec_value), .zero_hit(zero_hit)
  );

  dectimer_status #(.W(W)) u_status (
    .clk(clk), .rst(rst),
    .clr_en(wr_en && wr_sel == SEL_STAT), .clr_mask(wr_data),
    .set_dec(zero_hit), .set_fit(fit_event), .set_wdt(wdt_event),
    .stat_q(stat_q), .stat_nxt(stat_nxt)
  );

  dectimer_irq #(.W(W), .N(N_IRQ)) u_irq (
    .clk(clk), .rst(rst), .stat_nxt(stat_nxt), .ctrl_nxt(ctrl_nxt),
    .irq_q(irq_q)
  );

  assign irq_dec = irq_q[0];
  assign irq_fit = irq_q[1];
  assign irq_wdt = irq_q[2];
endmodule

// File: rtl/dectimer_chk.sv
module dectimer_chk
  import dectimer_pkg::*;
#(
  parameter int W = REG_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [W-1:0]     wr_data,
  input logic             tick,
  input logic             fit_event,
  input logic             wdt_event,
  input logic [W-1:0]     dec_value,
  input logic [W-1:0]     ctrl_q,
  input logic [W-1:0]     stat_q,
  input logic [W-1:0]     reload_q,
  input logic             irq_dec,
  input logic             irq_fit,
  input logic             irq_wdt
);
  logic wr_cnt;
  assign wr_cnt = wr_en && wr_sel == SEL_COUNT;

  p_irq_dec_r9: assert property (@(posedge clk) disable iff (rst)
    irq_dec == (stat_q[ST_DEC] && ctrl_q[CT_DEC_EN]));
  p_irq_fit_r9: assert property (@(posedge clk) disable iff (rst)
    irq_fit == (stat_q[ST_FIT] && ctrl_q[CT_FIT_EN]));
  p_irq_wdt_r9: assert property (@(posedge clk) disable iff (rst)
    irq_wdt == (stat_q[ST_WDT] && ctrl_q[CT_WDT_EN]));
  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CTRL) |=> ctrl_q == $past(wr_data));
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_STAT && wr_data[ST_FIT] && !fit_event) |=> !stat_q[ST_FIT]);
  p_fit_set_r4: assert property (@(posedge clk) disable iff (rst)
    fit_event |=> stat_q[ST_FIT]);
  p_wdt_set_r4: assert property (@(posedge clk) disable iff (rst)
    wdt_event |=> stat_q[ST_WDT]);
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && tick && dec_value > W'(1)) |=> dec_value == $past(dec_value) - W'(1));
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && tick && dec_value == W'(1)) |=> stat_q[ST_DEC]);
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && dec_value == '0) |=> dec_value == '0);
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && tick && dec_value == W'(1) && ctrl_q[CT_RELOAD]) |=> dec_value == $past(reload_q));
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> dec_value == $past(wr_data));
endmodule

bind dectimer_top dectimer_chk #(.W(W)) u_chk (.*);

// File: tb/test_dectimer_top.sv
module test_dectimer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        fit_event = 1'b0;
  logic        wdt_event = 1'b0;
  logic [31:0] dec_value, ctrl_q, stat_q;
  logic        irq_dec, irq_fit, irq_wdt;

  always #2.5 clk = ~clk;

  dectimer_top i_dectimer_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .fit_event(fit_event), .wdt_event(wdt_event),
    .dec_value(dec_value), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .irq_dec(irq_dec), .irq_fit(irq_fit), .irq_wdt(irq_wdt)
  );

  // behavioural reference model
  longint m_cnt, m_ctrl, m_stat, m_rel;
  bit m_idec, m_ifit, m_iwdt;
  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    longint c, ct, st, rl;
    cycles++;
    if (rst) begin
      m_cnt = 0; m_ctrl = 0; m_stat = 0; m_rel = 0;
    end else begin
      c = m_cnt; ct = m_ctrl; st = m_stat; rl = m_rel;
      if (wr_en && wr_sel == 2'd0) ct = wr_data;
      if (wr_en && wr_sel == 2'd2) rl = wr_data;
      if (wr_en && wr_sel == 2'd1) st = st & ~longint'(wr_data);
      if (wr_en && wr_sel == 2'd3) c = wr_data;
      else if (tick && m_cnt != 0) begin
        if (m_cnt == 1) begin
          st = st | (64'd1 << 27);
          c = m_ctrl[22] ? m_rel : 0;
        end else c = m_cnt - 1;
      end
      if (fit_event) st = st | (64'd1 << 26);
      if (wdt_event) st = st | (64'd1 << 30);
      m_cnt = c; m_ctrl = ct; m_stat = st & 64'hFFFF_FFFF; m_rel = rl;
    end
    m_idec = m_stat[27] && m_ctrl[26];
    m_ifit = m_stat[26] && m_ctrl[23];
    m_iwdt = m_stat[30] && m_ctrl[27];
  end

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      chk("dec_value", dec_value, m_cnt);
      chk("ctrl_q", ctrl_q, m_ctrl);
      chk("stat_q", stat_q, m_stat);
      chk("irq_dec", irq_dec, m_idec);
      chk("irq_fit", irq_fit, m_ifit);
      chk("irq_wdt", irq_wdt, m_iwdt);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; tick = 0; fit_event = 0; wdt_event = 0;
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d, logic tk);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; tick = tk; fit_event = 0; wdt_event = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; tick = 1; fit_event = 0; wdt_event = 0;
    end
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    @(negedge clk); rst = 0;
    idle(2);
    // direct check of reset values
    chk("reset irqs", {irq_dec, irq_fit, irq_wdt}, 0);

    cur_req = "R2";
    wr(2'd0, 32'hA5A5_5A5A, 0); idle(2);
    chk("ctrl direct", ctrl_q, 32'hA5A5_5A5A);
    wr(2'd0, 32'h0000_0000, 0); idle(1);

    cur_req = "R4";
    @(negedge clk); wr_en = 0; fit_event = 1; wdt_event = 1;
    idle(2);
    chk("fit/wdt flags", stat_q & 32'h4400_0000, 32'h4400_0000);
    // set and clear of bit 26 together: set wins
    @(negedge clk); wr_en = 1; wr_sel = 2'd1; wr_data = 32'h0400_0000; fit_event = 1;
    idle(2);
    chk("set wins", stat_q[26], 1);

    cur_req = "R9";
    wr(2'd0, 32'h0880_0000, 0); idle(2);   // fit and wdt enables
    chk("irq fit/wdt on", {irq_fit, irq_wdt}, 2'b11);
    wr(2'd0, 32'h0080_0000, 0); idle(2);
    chk("irq wdt off by enable", irq_wdt, 0);

    cur_req = "R3";
    wr(2'd1, 32'h0400_0000, 0); idle(2);
    chk("fit cleared, wdt kept", stat_q & 32'h4400_0000, 32'h4000_0000);
    wr(2'd1, 32'hFFFF_FFFF, 0); idle(2);
    chk("all cleared", stat_q, 0);

    cur_req = "R8";
    wr(2'd3, 32'd0, 0); idle(2);
    chk("write zero no flag", stat_q[27], 0);
    wr(2'd3, 32'd5, 1); idle(2);           // write beats tick
    chk("write wins over tick", dec_value, 5);

    cur_req = "R5";
    ticks(3); idle(1);
    chk("decrement", dec_value, 2);

    cur_req = "R6";
    wr(2'd0, 32'h0400_0000, 0);             // decrementer enable only
    ticks(2); idle(1);
    chk("zero flag", stat_q[27], 1);
    chk("irq dec", irq_dec, 1);
    wr(2'd1, 32'h0800_0000, 0); idle(1);
    ticks(5); idle(1);
    chk("holds at zero", dec_value, 0);
    chk("no new flag", stat_q[27], 0);

    cur_req = "R10";
    wr(2'd3, 32'd3, 0);
    wr(2'd2, 32'd100, 1); idle(2);
    chk("reload write leaves counter", dec_value, 2);

    cur_req = "R7";
    wr(2'd0, 32'h0440_0000, 0);
    ticks(2); idle(1);
    chk("reloaded", dec_value, 100);
    chk("flag on reload", stat_q[27], 1);
    // reload value rewritten in the cycle of the crossing: old value used
    wr(2'd3, 32'd1, 0);
    wr(2'd2, 32'd7, 1); idle(2);
    chk("old reload used", dec_value, 100);
    // clear bit 27 in same cycle as crossing: set wins
    wr(2'd3, 32'd1, 0);
    wr(2'd1, 32'h0800_0000, 1); idle(2);
    chk("crossing beats clear", stat_q[27], 1);
    chk("reload new", dec_value, 7);

    cur_req = "R5";
    wr(2'd3, 32'hFFFF_FFFF, 0);
    ticks(4); idle(1);
    chk("top decrement", dec_value, 32'hFFFF_FFFB);

    cur_req = "R1";
    @(negedge clk); rst = 1; idle(2);
    @(negedge clk); rst = 0; idle(1);
    chk("reset clears", {dec_value, ctrl_q, stat_q}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule